// File: doc/BRIEF.md
# Thirteen-Pin GPIO Controller with Grouped Edge Interrupts

This block is a register-mapped general-purpose I/O controller for thirteen pins. It sits on a simple byte-wide register bus with address, write data, write enable, read enable and registered read data. Each pin has two control bytes. The drive byte sets the output level, the direction, push-pull versus open-drain driving, and a stored pull selection that is exported but has no analog effect here. The sense byte selects which input edges raise an interrupt, and its bit 0 reads back the synchronised pin level.

Every pin input passes through a two-flop synchroniser. An edge is found by comparing the synchronised level with its value one cycle earlier. A matching edge sets a sticky status bit in one of two groups: pins 0 to 6 go to the first group and pins 7 to 12 to the second. Software clears a status bit by writing 1 to it. Per-pin mask bits gate the status bits onto one level-sensitive interrupt line.

Software writes the drive bytes to configure the pins and the sense bytes to arm detection, clears masks to enable interrupts, and services the interrupt line by reading and clearing the status bytes.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every drive and sense byte reads 0x00, both status bytes read 0x00, the mask bytes read 0x7F (address 0x22) and 0x3F (address 0x23), all output enables are 0 and `irq` is 0.
- R2: The drive byte of pin p is at address p (0x00 to 0x0C). It stores bit 0 as the output level, bits 2:1 as the pull selection, bit 3 as the pull enable, bit 4 as the drive mode (1 = push-pull) and bit 5 as the direction (1 = output). Bits 7:6 read 0. The pull fields appear on `pin_pull_sel[2p+1:2p]` and `pin_pull_en[p]`.
- R3: `pin_out[p]` equals drive bit 0. `pin_oe[p]` is 1 only when the direction is output and either push-pull is selected or the output level is 0.
- R4: The sense byte of pin p is at address 0x0D+p. Its bit 0 returns the pin level after a two-flop synchroniser: a read whose capture edge is the second clock edge after an input change still returns the old level, and the read on the third edge returns the new level.
- R5: Sense bits 2:1 select detection: 00 none, 01 falling edge, 10 rising edge, 11 both edges. The status bit of a pin sets on the third clock edge after a matching input change.
- R6: The status of pins 0 to 6 is at address 0x20, bits 6:0. The status of pins 7 to 12 is at address 0x21, bits 5:0, with pin 7 in bit 0. The mask bytes at 0x22 and 0x23 use the same bit mapping.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A detected edge in the same cycle as a clear of the same bit leaves the bit set. A status bit is never cleared without a write.
- R8: Status bits set whether or not the pin is masked. `irq` is high exactly while some status bit has a mask bit of 0.
- R9: Unused upper bits of the status and mask bytes read as 0 and ignore writes. Sense bits 7:3 read as 0 and ignore writes.
- R10: A read from any address outside 0x00 to 0x19 and 0x20 to 0x23 returns 0x00, and a write there changes no state.
- R11: `bus_rdata` is loaded on the clock edge where `bus_re` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 13 | Raw pin inputs, asynchronous |
| pin_out | output | 13 | Output level per pin |
| pin_oe | output | 13 | Driver enable per pin |
| pin_pushpull | output | 13 | Drive mode per pin, 1 = push-pull |
| pin_pull_en | output | 13 | Stored pull enable per pin |
| pin_pull_sel | output | 26 | Stored pull selection, two bits per pin |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets the boundary between the two status groups: pins 7 and 12 must land in bits 0 and 5 of the second byte. An off-by-one in that mapping would set a bit in the wrong byte, or drop the edge. A clear that collides with a new edge must leave the bit set, because a design where the clear wins would lose an interrupt. The bench also checks open-drain driving while the output level is high, which a design that ignores the level would wrongly drive. The level readback is timed to the exact edge, so a synchroniser with one stage too few or too many shows up as a read returning its value one cycle early or late. Writes to unused bits and unmapped addresses are followed by readbacks, to catch any state they wrongly change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   // Edge-detect selection held in bits 2:1 of each sense byte
   typedef enum logic [1:0] {
      DET_OFF  = 2'b00,
      DET_FALL = 2'b01,
      DET_RISE = 2'b10,
      DET_ANY  = 2'b11
   } det_e;

   // Drive byte, bit 5 down to bit 0
   typedef struct packed {
      logic       dir;
      logic       push_pull;
      logic       pull_en;
      logic [1:0] pull_sel;
      logic       level;
   } drv_cfg_t;

   localparam int DRV_CFG_W = $bits(drv_cfg_t);
   localparam int DET_W     = $bits(det_e);

   function automatic logic edge_hit(det_e mode, logic rise, logic fall);
      logic hit;
      case (mode)
         DET_FALL: hit = fall;
         DET_RISE: hit = rise;
         DET_ANY:  hit = rise | fall;
         default:  hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
   import gpio_bank_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  det_e det_i,
   output logic level_o,
   output logic hit_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise    = level_o & ~prev_q;
   assign fall    = ~level_o & prev_q;
   assign hit_o   = edge_hit(det_i, rise, fall);

endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
   import gpio_bank_pkg::*;
#(
   parameter bit OD_SUPPORT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 drv_we,
   input  logic                 sns_we,
   input  logic [DRV_CFG_W-1:0] drv_data,
   input  logic [DET_W-1:0]     sns_data,
   output drv_cfg_t             cfg_o,
   output det_e                 det_o,
   output logic                 drv_o,
   output logic                 oe_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_o <= '0;
         det_o <= DET_OFF;
      end else begin
         if (drv_we) cfg_o <= drv_cfg_t'(drv_data);
         if (sns_we) det_o <= det_e'(sns_data);
      end
   end

   assign drv_o = cfg_o.level;

   generate
      if (OD_SUPPORT) begin : g_od
         // open-drain pulls low only; push-pull drives both levels
         assign oe_o = cfg_o.dir & (cfg_o.push_pull | ~cfg_o.level);
      end else begin : g_pp_only
         assign oe_o = cfg_o.dir;
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
   parameter int WIDTH = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] hit_i,
   input  logic             stat_we,
   input  logic             mask_we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] stat_o,
   output logic [WIDTH-1:0] mask_o,
   output logic             pend_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("gpio_irq_group: WIDTH must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_o <= '0;
         mask_o <= '1;
      end else begin
         // a fresh hit overrides a same-cycle clear
         if (stat_we) stat_o <= (stat_o & ~wdata) | hit_i;
         else         stat_o <= stat_o | hit_i;
         if (mask_we) mask_o <= wdata;
      end
   end

   assign pend_o = |(stat_o & ~mask_o);

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 13,
   parameter int GRP0_PINS   = 7,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DRV_BASE    = 'h00,
   parameter int STAT_BASE   = 'h20,
   parameter int MASK_BASE   = 'h22,
   parameter bit OD_SUPPORT  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   input  logic                  bus_we,
   input  logic                  bus_re,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [NUM_PINS-1:0]   pin_in,
   output logic [NUM_PINS-1:0]   pin_out,
   output logic [NUM_PINS-1:0]   pin_oe,
   output logic [NUM_PINS-1:0]   pin_pushpull,
   output logic [NUM_PINS-1:0]   pin_pull_en,
   output logic [2*NUM_PINS-1:0] pin_pull_sel,
   output logic                  irq
);

   localparam int GRP1_PINS = NUM_PINS - GRP0_PINS;
   localparam int SNS_BASE  = DRV_BASE + NUM_PINS;
   localparam int ADDR_LIM  = 1 << ADDR_W;

   // ---------------- elaboration checks ----------------
   generate
      if (GRP0_PINS < 1 || GRP1_PINS < 1) begin : g_bad_split
         $error("gpio_bank_ctrl: both interrupt groups need at least one pin");
      end
      if (GRP0_PINS > DATA_W || GRP1_PINS > DATA_W) begin : g_bad_group
         $error("gpio_bank_ctrl: a group is wider than the data bus");
      end
      if (DATA_W < DRV_CFG_W) begin : g_bad_data
         $error("gpio_bank_ctrl: data bus narrower than the drive byte");
      end
      if (SNS_BASE + NUM_PINS > ADDR_LIM || STAT_BASE + 2 > ADDR_LIM ||
          MASK_BASE + 2 > ADDR_LIM) begin : g_bad_range
         $error("gpio_bank_ctrl: register window exceeds address space");
      end
      if ((STAT_BASE < SNS_BASE + NUM_PINS && STAT_BASE + 2 > DRV_BASE) ||
          (MASK_BASE < SNS_BASE + NUM_PINS && MASK_BASE + 2 > DRV_BASE) ||
          (MASK_BASE < STAT_BASE + 2 && MASK_BASE + 2 > STAT_BASE)) begin : g_bad_overlap
         $error("gpio_bank_ctrl: register windows overlap");
      end
   endgenerate

   // ---------------- per-pin control and sensing ----------------
   drv_cfg_t            cfg_w [NUM_PINS];
   det_e                det_w [NUM_PINS];
   logic [NUM_PINS-1:0] level_w;
   logic [NUM_PINS-1:0] hit_w;
   logic [NUM_PINS-1:0] dir_vec;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
         gpio_pin_ctl #(
            .OD_SUPPORT (OD_SUPPORT)
         ) u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .drv_we   (bus_we && bus_addr == ADDR_W'(DRV_BASE + gi)),
            .sns_we   (bus_we && bus_addr == ADDR_W'(SNS_BASE + gi)),
            .drv_data (bus_wdata[DRV_CFG_W-1:0]),
            .sns_data (bus_wdata[DET_W:1]),
            .cfg_o    (cfg_w[gi]),
            .det_o    (det_w[gi]),
            .drv_o    (pin_out[gi]),
            .oe_o     (pin_oe[gi])
         );

         gpio_pin_sync #(
            .STAGES (SYNC_STAGES)
         ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_in[gi]),
            .det_i   (det_w[gi]),
            .level_o (level_w[gi]),
            .hit_o   (hit_w[gi])
         );

         assign pin_pushpull[gi]          = cfg_w[gi].push_pull;
         assign pin_pull_en[gi]           = cfg_w[gi].pull_en;
         assign pin_pull_sel[2*gi +: 2]   = cfg_w[gi].pull_sel;
         assign dir_vec[gi]               = cfg_w[gi].dir;
      end
   endgenerate

   // ---------------- interrupt groups ----------------
   logic [GRP0_PINS-1:0] g0_stat, g0_mask;
   logic [GRP1_PINS-1:0] g1_stat, g1_mask;
   logic                 g0_pend, g1_pend;
   logic [NUM_PINS-1:0]  stat_all, mask_all;

   gpio_irq_group #(
      .WIDTH (GRP0_PINS)
   ) u_grp0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit_w[GRP0_PINS-1:0]),
      .stat_we (bus_we && bus_addr == ADDR_W'(STAT_BASE)),
      .mask_we (bus_we && bus_addr == ADDR_W'(MASK_BASE)),
      .wdata   (bus_wdata[GRP0_PINS-1:0]),
      .stat_o  (g0_stat),
      .mask_o  (g0_mask),
      .pend_o  (g0_pend)
   );

   gpio_irq_group #(
      .WIDTH (GRP1_PINS)
   ) u_grp1 (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit_w[NUM_PINS-1:GRP0_PINS]),
      .stat_we (bus_we && bus_addr == ADDR_W'(STAT_BASE + 1)),
      .mask_we (bus_we && bus_addr == ADDR_W'(MASK_BASE + 1)),
      .wdata   (bus_wdata[GRP1_PINS-1:0]),
      .stat_o  (g1_stat),
      .mask_o  (g1_mask),
      .pend_o  (g1_pend)
   );

   assign stat_all = {g1_stat, g0_stat};
   assign mask_all = {g1_mask, g0_mask};
   assign irq      = g0_pend | g1_pend;

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (bus_addr == ADDR_W'(DRV_BASE + p)) rd_mux = DATA_W'(cfg_w[p]);
         if (bus_addr == ADDR_W'(SNS_BASE + p)) rd_mux = DATA_W'({det_w[p], level_w[p]});
      end
      if (bus_addr == ADDR_W'(STAT_BASE))     rd_mux[GRP0_PINS-1:0] = g0_stat;
      if (bus_addr == ADDR_W'(STAT_BASE + 1)) rd_mux[GRP1_PINS-1:0] = g1_stat;
      if (bus_addr == ADDR_W'(MASK_BASE))     rd_mux[GRP0_PINS-1:0] = g0_mask;
      if (bus_addr == ADDR_W'(MASK_BASE + 1)) rd_mux[GRP1_PINS-1:0] = g1_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rd_mux;
   end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
   parameter int NUM_PINS  = 13,
   parameter int GRP0_PINS = 7,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int DRV_BASE  = 'h00,
   parameter int STAT_BASE = 'h20,
   parameter int MASK_BASE = 'h22
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic                bus_we,
   input logic                bus_re,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NUM_PINS-1:0] pin_pushpull,
   input logic                irq,
   input logic [NUM_PINS-1:0] stat_all,
   input logic [NUM_PINS-1:0] mask_all,
   input logic [NUM_PINS-1:0] dir_vec
);

   localparam int                GRP1_PINS = NUM_PINS - GRP0_PINS;
   localparam int                MAP_END   = DRV_BASE + 2 * NUM_PINS;
   localparam logic [DATA_W-1:0] G1_FIELD  = DATA_W'((1 << GRP1_PINS) - 1);

   logic mapped;
   always_comb begin
      mapped = (int'(bus_addr) >= DRV_BASE && int'(bus_addr) < MAP_END) ||
               (int'(bus_addr) == STAT_BASE) || (int'(bus_addr) == STAT_BASE + 1) ||
               (int'(bus_addr) == MASK_BASE) || (int'(bus_addr) == MASK_BASE + 1);
   end

   // R10: unmapped reads return zero
   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !mapped) |=> (bus_rdata == '0));

   // R7: a status bit only falls through a bus write
   p_stat_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> ((stat_all & $past(stat_all)) == $past(stat_all)));

   // R3: no pin is driven while configured as input
   p_oe_needs_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & ~dir_vec) == '0));

   // R3: open-drain pins never drive a high level
   p_od_low_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & ~pin_pushpull & pin_out) == '0));

   // R8: the request line needs an unmasked pending source
   p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((stat_all & ~mask_all) != '0));

   // R9: second mask byte keeps only its low field of a write
   p_mask_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(MASK_BASE + 1)) |=>
      (DATA_W'(mask_all[NUM_PINS-1:GRP0_PINS]) == ($past(bus_wdata) & G1_FIELD)));

   // R9: masks are stable without a write
   p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(mask_all));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
   .NUM_PINS  (NUM_PINS),
   .GRP0_PINS (GRP0_PINS),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .DRV_BASE  (DRV_BASE),
   .STAT_BASE (STAT_BASE),
   .MASK_BASE (MASK_BASE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .bus_we       (bus_we),
   .bus_re       (bus_re),
   .bus_rdata    (bus_rdata),
   .pin_out      (pin_out),
   .pin_oe       (pin_oe),
   .pin_pushpull (pin_pushpull),
   .irq          (irq),
   .stat_all     (stat_all),
   .mask_all     (mask_all),
   .dir_vec      (dir_vec)
);

// File: tb/gpio_bank_ctrl_tb.sv
`timescale 1ns/100ps
module gpio_bank_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [7:0]  bus_rdata;
   logic [12:0] pin_in = '0;
   logic [12:0] pin_out, pin_oe, pin_pushpull, pin_pull_en;
   logic [25:0] pin_pull_sel;
   logic        irq;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   gpio_bank_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_pushpull(pin_pushpull),
      .pin_pull_en(pin_pull_en), .pin_pull_sel(pin_pull_sel), .irq(irq)
   );

   // ---------------- behavioural reference ----------------
   int        m_drv [13];
   int        m_sns [13];
   bit [12:0] m_s1, m_s2, m_old, m_stat, m_mask;
   bit [7:0]  m_rd;

   function automatic bit [7:0] model_read(int a);
      if (a >= 0 && a <= 12)  return 8'(m_drv[a]);
      if (a >= 13 && a <= 25) return 8'((m_sns[a-13] << 1) | int'(m_s2[a-13]));
      if (a == 32) return {1'b0, m_stat[6:0]};
      if (a == 33) return {2'b00, m_stat[12:7]};
      if (a == 34) return {1'b0, m_mask[6:0]};
      if (a == 35) return {2'b00, m_mask[12:7]};
      return 8'h00;
   endfunction

   always @(posedge clk) begin
      bit [12:0] hit;
      if (!rst_n) begin
         for (int p = 0; p < 13; p++) begin m_drv[p] = 0; m_sns[p] = 0; end
         m_s1 = '0; m_s2 = '0; m_old = '0; m_stat = '0; m_mask = '1; m_rd = '0;
      end else begin
         if (bus_re) m_rd = model_read(int'(bus_addr));
         for (int p = 0; p < 13; p++) begin
            bit up, dn;
            up = m_s2[p] && !m_old[p];
            dn = !m_s2[p] && m_old[p];
            case (m_sns[p])
               1: hit[p] = dn;
               2: hit[p] = up;
               3: hit[p] = up || dn;
               default: hit[p] = 1'b0;
            endcase
         end
         if (bus_we) begin
            int a;
            a = int'(bus_addr);
            if (a <= 12) m_drv[a] = int'(bus_wdata) & 63;
            else if (a <= 25) m_sns[a-13] = (int'(bus_wdata) >> 1) & 3;
            else if (a == 32) m_stat[6:0] = m_stat[6:0] & ~bus_wdata[6:0];
            else if (a == 33) m_stat[12:7] = m_stat[12:7] & ~bus_wdata[5:0];
            else if (a == 34) m_mask[6:0] = bus_wdata[6:0];
            else if (a == 35) m_mask[12:7] = bus_wdata[5:0];
         end
         m_stat = m_stat | hit;
         m_old = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      end
   end

   task automatic chk(string req, int act, int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit [12:0] e_out, e_oe, e_pp, e_pe;
         bit [25:0] e_ps;
         for (int p = 0; p < 13; p++) begin
            bit dir, pp, lv;
            lv = m_drv[p][0]; pp = m_drv[p][4]; dir = m_drv[p][5];
            e_out[p] = lv;
            e_oe[p]  = dir && (pp || !lv);
            e_pp[p]  = pp;
            e_pe[p]  = m_drv[p][3];
            e_ps[2*p +: 2] = 2'(m_drv[p] >> 1);
         end
         chk("R11 rdata", int'(bus_rdata), int'(m_rd));
         chk("R8 irq", int'(irq), int'(|(m_stat & ~m_mask)));
         chk("R3 pin_out", int'(pin_out), int'(e_out));
         chk("R3 pin_oe", int'(pin_oe), int'(e_oe));
         chk("R3 pushpull", int'(pin_pushpull), int'(e_pp));
         chk("R2 pull_en", int'(pin_pull_en), int'(e_pe));
         chk("R2 pull_sel", int'(pin_pull_sel), int'(e_ps));
      end
   end

   // ---------------- bus tasks ----------------
   task automatic tick(int n);
      for (int k = 0; k < n; k++) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic wr(int a, int d);
      bus_addr = 8'(a); bus_wdata = 8'(d); bus_we = 1'b1;
      tick(1);
      bus_we = 1'b0;
   endtask

   task automatic rd(int a, int exp, string req);
      bus_addr = 8'(a); bus_re = 1'b1;
      tick(1);
      bus_re = 1'b0;
      chk(req, int'(bus_rdata), exp);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset values
      rd(8'h00, 8'h00, "R1 drive byte");
      rd(8'h0D, 8'h00, "R1 sense byte");
      rd(8'h20, 8'h00, "R1 status0");
      rd(8'h21, 8'h00, "R1 status1");
      rd(8'h22, 8'h7F, "R1 mask0");
      rd(8'h23, 8'h3F, "R1 mask1");
      chk("R1 irq", int'(irq), 0);
      chk("R1 oe", int'(pin_oe), 0);

      // R10 unmapped
      rd(8'h1A, 8'h00, "R10 gap low");
      rd(8'h1F, 8'h00, "R10 gap high");
      rd(8'h24, 8'h00, "R10 past masks");
      rd(8'hFF, 8'h00, "R10 top");
      wr(8'hFF, 8'hFF);
      wr(8'h1A, 8'hFF);
      rd(8'h22, 8'h7F, "R10 mask0 untouched");
      rd(8'h00, 8'h00, "R10 drive untouched");

      // R2 drive byte fields
      wr(8'h00, 8'hFF);
      rd(8'h00, 8'h3F, "R2 upper bits zero");
      chk("R2 pull_sel pin0", int'(pin_pull_sel[1:0]), 3);
      chk("R2 pull_en pin0", int'(pin_pull_en[0]), 1);
      wr(8'h0C, 8'h16);
      rd(8'h0C, 8'h16, "R2 pin12 readback");
      chk("R2 pull_sel pin12", int'(pin_pull_sel[25:24]), 3);
      chk("R2 pull_en pin12", int'(pin_pull_en[12]), 0);

      // R3 drive modes
      wr(8'h03, 8'h21);
      wr(8'h04, 8'h20);
      wr(8'h05, 8'h10);
      chk("R3 pushpull high drives", int'(pin_oe[0]), 1);
      chk("R3 open-drain high floats", int'(pin_oe[3]), 0);
      chk("R3 open-drain high level", int'(pin_out[3]), 1);
      chk("R3 open-drain low drives", int'(pin_oe[4]), 1);
      chk("R3 input not driven", int'(pin_oe[5]), 0);

      // R4 synchroniser latency
      pin_in[2] = 1'b1;
      tick(2);
      rd(8'h0F, 8'h01, "R4 level high third edge");
      pin_in[2] = 1'b0;
      tick(1);
      rd(8'h0F, 8'h01, "R4 old level second edge");
      rd(8'h0F, 8'h00, "R4 new level third edge");

      // R5 detect modes: pin0 rise, pin1 fall, pin2 both, pin3 off
      wr(8'h0D, 8'h04);
      wr(8'h0E, 8'h02);
      wr(8'h0F, 8'h06);
      wr(8'h10, 8'h00);
      rd(8'h0E, 8'h02, "R5 sense readback");
      pin_in[3:0] = 4'hF;
      tick(4);
      rd(8'h20, 8'h05, "R5 rising edges");
      wr(8'h20, 8'h7F);
      pin_in[3:0] = 4'h0;
      tick(4);
      rd(8'h20, 8'h06, "R5 falling edges");

      // R6 group boundary: pin7 and pin12 rising
      wr(8'h14, 8'h04);
      wr(8'h19, 8'h04);
      pin_in[7] = 1'b1; pin_in[12] = 1'b1;
      tick(4);
      rd(8'h21, 8'h21, "R6 group1 bits");
      rd(8'h20, 8'h06, "R6 group0 unchanged");

      // R8 masking
      chk("R8 masked pending no irq", int'(irq), 0);
      wr(8'h23, 8'h3E);
      chk("R8 unmasked irq", int'(irq), 1);
      wr(8'h21, 8'h01);
      chk("R8 cleared irq", int'(irq), 0);
      rd(8'h21, 8'h20, "R8 masked bit stays");

      // R7 write-one-to-clear and collision
      wr(8'h20, 8'h00);
      rd(8'h20, 8'h06, "R7 zero write keeps");
      wr(8'h20, 8'h02);
      rd(8'h20, 8'h04, "R7 one write clears");
      pin_in[0] = 1'b1;
      tick(2);
      wr(8'h20, 8'h01);
      rd(8'h20, 8'h05, "R7 set wins over clear");

      // R9 unused bits
      wr(8'h23, 8'hFF);
      rd(8'h23, 8'h3F, "R9 mask1 upper");
      wr(8'h22, 8'hFF);
      rd(8'h22, 8'h7F, "R9 mask0 upper");
      wr(8'h20, 8'h80);
      rd(8'h20, 8'h05, "R9 status upper write");
      wr(8'h10, 8'hFF);
      rd(8'h10, 8'h06, "R9 sense upper");
      wr(8'h10, 8'h00);

      // R11 read data holds without a strobe
      rd(8'h00, 8'h3F, "R11 read");
      bus_addr = 8'h22;
      tick(2);
      chk("R11 hold", int'(bus_rdata), 8'h3F);

      // mixed traffic against the reference
      for (int n = 0; n < 4000; n++) begin
         int op;
         if ($urandom % 6 == 0) pin_in[$urandom % 13] = ~pin_in[$urandom % 13];
         op = int'($urandom % 4);
         bus_addr  = 8'($urandom % 40);
         bus_wdata = 8'($urandom);
         bus_we    = (op == 1);
         bus_re    = (op >= 2);
         tick(1);
         bus_we = 1'b0; bus_re = 1'b0;
      end

      tick(4);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule